// File: doc/BRIEF.md
# Egress Timestamp Polling Engine

After a switch port transmits a frame, the MAC latches a partial egress timestamp into a per-port status register. This engine fetches that value. A one-cycle start strobe names the port and the register layout. The engine then issues reads on a simple request/response register-read interface. It inspects a fixed update flag in each response. When a response is not ready, the engine waits a programmable number of clock cycles before it reads again, up to a bounded number of attempts.

Once a response shows the update flag, the engine cuts the timestamp out of the payload and presents it zero-extended to 32 bits. The position of the timestamp depends on the layout. The short layout is one 32-bit word. The long layout is two 32-bit words.

Every operation ends with a one-cycle done pulse. The pulse carries one of three outcomes: success, a timeout, or an error passed on from the read interface. Turning the partial value into a full time and running the serial transport both happen outside this block.

Top module: `egress_ts_poller`

## Requirements
- R1: Each read request carries the address `BASE_ADDR + port * ADDR_STRIDE` for the port captured at start. `rdWideO` is 1 for the long (64-bit) layout and 0 for the short (32-bit) layout.
- R2: Polling stops on the first response whose bit 0 (update flag) is 1. `doneO` rises in the cycle after the clock edge that accepted that response.
- R3: At most `MAX_READS` reads are issued per operation. If none of them shows bit 0 set, `doneO` comes with `timeoutO`=1 and `tsO`=0, and no further read follows.
- R4: After a not-ready response, the next read request appears exactly `GAP_CYCLES` clock edges after the edge that accepted the response.
- R5: In the short layout, `tsO` equals payload bits [31:8], zero-extended; bits [63:32] and [7:1] have no effect.
- R6: In the long layout, `tsO` equals payload bits [63:32]; bits [31:1] have no effect.
- R7: A response with `rdRspErrI`=1 ends the operation at once with `errO`=1 and `tsO`=0, even if bit 0 is set, and no further read follows.
- R8: `doneO` is high for exactly one cycle. `errO` and `timeoutO` are never high together, and each is high only with `doneO`.
- R9: A start strobe that arrives while an operation is running is ignored. It causes no read to another port and no extra done pulse.
- R10: After reset, `rdReqO` and `doneO` are low until a start is received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startI | input | 1 | One-cycle request to fetch a timestamp |
| portI | input | PORT_W | Port whose register is read |
| wideI | input | 1 | Layout select: 1 = 64-bit, 0 = 32-bit |
| rdReqO | output | 1 | One-cycle read request |
| rdAddrO | output | ADDR_W | Register address of the read |
| rdWideO | output | 1 | Read length: 1 = 8 bytes, 0 = 4 bytes |
| rdRspValidI | input | 1 | Read response strobe |
| rdRspErrI | input | 1 | Read response carries an error |
| rdRspDataI | input | 64 | Read payload (short layout uses bits 31:0) |
| doneO | output | 1 | One-cycle end-of-operation pulse |
| tsO | output | 32 | Partial timestamp, zero-extended |
| timeoutO | output | 1 | Operation ended without the update flag |
| errO | output | 1 | Operation ended on a read error |

## Verification
Two results are time-critical. The done pulse, together with its flags and timestamp, is due one cycle after the edge that accepts the final response. A retried read request is due `GAP_CYCLES + 1` cycles after a not-ready response is driven. The bench responder drives every response on a falling edge and records the cycle number. The monitor then compares the falling edge at which done appears, and the one at which the next request appears, against those fixed offsets rather than waiting loosely. The read count of each operation is compared too, and the cycle after every done must show the pulse gone.

// File: rtl/egress_ts_pkg.sv
package egress_ts_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_RSP,
    ST_GAP
  } pollState_t;

  // Strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic capture;   // latch port and layout, clear read count
    logic issue;     // a read is being requested
    logic gapLoad;   // start the inter-read wait
    logic gapTick;   // count the wait down
    logic finOk;     // finish with extracted timestamp
    logic finErr;    // finish with read error
    logic finTmo;    // finish with timeout
  } dpCtl_t;

endpackage

// File: rtl/egress_ts_datapath.sv
module egress_ts_datapath
  import egress_ts_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int ADDR_W      = 16,
  parameter int BASE_ADDR   = 32'h100,
  parameter int ADDR_STRIDE = 2,
  parameter int MAX_READS   = 10,
  parameter int GAP_CYCLES  = 2000
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtl_t              ctl,
  input  logic [(NUM_PORTS > 1 ? $clog2(NUM_PORTS) : 1)-1:0] portI,
  input  logic                wideI,
  input  logic [63:0]         rdDataI,
  output logic [ADDR_W-1:0]   rdAddrO,
  output logic                rdWideO,
  output logic                gapZeroO,
  output logic                lastReadO,
  output logic                doneO,
  output logic [31:0]         tsO,
  output logic                timeoutO,
  output logic                errO
);

  localparam int PORT_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int TBL_N       = 1 << PORT_W;
  localparam int CNT_W       = $clog2(MAX_READS + 1);
  localparam int GAP_W       = $clog2(GAP_CYCLES + 1);
  localparam int NARROW_TS_W = 24;
  localparam int NARROW_LSB  = 32 - NARROW_TS_W;
  localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(MAX_READS);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(GAP_CYCLES - 1);

  logic [PORT_W-1:0] portQ;
  logic              wideQ;
  logic [CNT_W-1:0]  readCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic [31:0]       tsField;
  logic [ADDR_W-1:0] addrTable [TBL_N];
  logic              unusedLowBits;

  // Per-port register address table
  for (genvar g = 0; g < TBL_N; g++) begin : gAddr
    if (g < NUM_PORTS) begin : gValid
      assign addrTable[g] = ADDR_W'(BASE_ADDR + g * ADDR_STRIDE);
    end else begin : gSpare
      assign addrTable[g] = ADDR_W'(BASE_ADDR);
    end
  end

  assign rdAddrO   = addrTable[portQ];
  assign rdWideO   = wideQ;
  assign gapZeroO  = (gapCnt == '0);
  assign lastReadO = (readCnt == MAX_CNT);

  // Field position depends on the layout; bit 0 is the flag in both
  always_comb begin
    if (wideQ) tsField = rdDataI[63:32];
    else       tsField = 32'(rdDataI[31:NARROW_LSB]);
  end
  assign unusedLowBits = ^rdDataI[NARROW_LSB-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portQ    <= '0;
      wideQ    <= 1'b0;
      readCnt  <= '0;
      gapCnt   <= '0;
      doneO    <= 1'b0;
      tsO      <= '0;
      timeoutO <= 1'b0;
      errO     <= 1'b0;
    end else begin
      doneO    <= 1'b0;
      timeoutO <= 1'b0;
      errO     <= 1'b0;
      if (ctl.capture) begin
        portQ   <= portI;
        wideQ   <= wideI;
        readCnt <= '0;
      end
      if (ctl.issue) readCnt <= readCnt + CNT_W'(1);
      if (ctl.gapLoad)      gapCnt <= GAP_LOAD;
      else if (ctl.gapTick) gapCnt <= gapCnt - GAP_W'(1);
      if (ctl.finOk) begin
        doneO <= 1'b1;
        tsO   <= tsField;
      end
      if (ctl.finErr) begin
        doneO <= 1'b1;
        errO  <= 1'b1;
        tsO   <= '0;
      end
      if (ctl.finTmo) begin
        doneO    <= 1'b1;
        timeoutO <= 1'b1;
        tsO      <= '0;
      end
    end
  end

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneO |=> !doneO);
  // R8
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(errO && timeoutO) && ((errO || timeoutO) -> doneO));
  // R3
  read_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    readCnt <= MAX_CNT);
  // R7
  fail_ts_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errO || timeoutO) |-> (tsO == '0));

endmodule

// File: rtl/egress_ts_ctrl.sv
module egress_ts_ctrl
  import egress_ts_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startI,
  input  logic   rdRspValidI,
  input  logic   rdRspErrI,
  input  logic   readyBitI,
  input  logic   gapZeroI,
  input  logic   lastReadI,
  output logic   rdReqO,
  output dpCtl_t ctl
);

  pollState_t state, stateNext;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (startI) begin
          ctl.capture = 1'b1;
          stateNext   = ST_REQ;
        end
      end
      ST_REQ: begin
        ctl.issue = 1'b1;
        stateNext = ST_RSP;
      end
      ST_RSP: begin
        if (rdRspValidI) begin
          if (rdRspErrI) begin
            ctl.finErr = 1'b1;
            stateNext  = ST_IDLE;
          end else if (readyBitI) begin
            ctl.finOk = 1'b1;
            stateNext = ST_IDLE;
          end else if (lastReadI) begin
            ctl.finTmo = 1'b1;
            stateNext  = ST_IDLE;
          end else begin
            ctl.gapLoad = 1'b1;
            stateNext   = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (gapZeroI) stateNext = ST_REQ;
        else          ctl.gapTick = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign rdReqO = (state == ST_REQ);

  // R7
  err_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RSP && rdRspValidI && rdRspErrI) |=> (state == ST_IDLE));
  // R2
  ready_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RSP && rdRspValidI && readyBitI) |=> (state == ST_IDLE));
  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !ctl.capture);

endmodule

// File: rtl/egress_ts_poller.sv
module egress_ts_poller
  import egress_ts_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int ADDR_W      = 16,
  parameter int BASE_ADDR   = 32'h100,
  parameter int ADDR_STRIDE = 2,
  parameter int MAX_READS   = 10,
  parameter int GAP_CYCLES  = 2000,
  localparam int PORT_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startI,
  input  logic [PORT_W-1:0] portI,
  input  logic              wideI,
  output logic              rdReqO,
  output logic [ADDR_W-1:0] rdAddrO,
  output logic              rdWideO,
  input  logic              rdRspValidI,
  input  logic              rdRspErrI,
  input  logic [63:0]       rdRspDataI,
  output logic              doneO,
  output logic [31:0]       tsO,
  output logic              timeoutO,
  output logic              errO
);

  dpCtl_t ctl;
  logic   gapZero;
  logic   lastRead;

  egress_ts_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startI     (startI),
    .rdRspValidI(rdRspValidI),
    .rdRspErrI  (rdRspErrI),
    .readyBitI  (rdRspDataI[0]),
    .gapZeroI   (gapZero),
    .lastReadI  (lastRead),
    .rdReqO     (rdReqO),
    .ctl        (ctl)
  );

  egress_ts_datapath #(
    .NUM_PORTS  (NUM_PORTS),
    .ADDR_W     (ADDR_W),
    .BASE_ADDR  (BASE_ADDR),
    .ADDR_STRIDE(ADDR_STRIDE),
    .MAX_READS  (MAX_READS),
    .GAP_CYCLES (GAP_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .portI    (portI),
    .wideI    (wideI),
    .rdDataI  (rdRspDataI),
    .rdAddrO  (rdAddrO),
    .rdWideO  (rdWideO),
    .gapZeroO (gapZero),
    .lastReadO(lastRead),
    .doneO    (doneO),
    .tsO      (tsO),
    .timeoutO (timeoutO),
    .errO     (errO)
  );

  // R3
  no_read_after_tmo_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeoutO |-> !rdReqO);

endmodule

// File: tb/sim_egress_ts_poller.sv
module sim_egress_ts_poller;

  localparam int NP     = 4;
  localparam int AW     = 16;
  localparam int BASE   = 32'h100;
  localparam int STRIDE = 2;
  localparam int MR     = 10;
  localparam int G      = 12;
  localparam int LAT    = 2;

  typedef struct {
    int          kind;   // 0 ok, 1 err, 2 timeout
    logic [31:0] ts;
    int          reads;
  } exp_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startI = 1'b0;
  logic [1:0]    portI = '0;
  logic          wideI = 1'b0;
  logic          rdReqO, rdWideO;
  logic [AW-1:0] rdAddrO;
  logic          rdRspValidI = 1'b0;
  logic          rdRspErrI = 1'b0;
  logic [63:0]   rdRspDataI = '0;
  logic          doneO, timeoutO, errO;
  logic [31:0]   tsO;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int opsDone = 0;
  exp_t expQ[$];

  int          curBusy, curKind, curPort, readsSeen, lastRspCyc;
  bit          curWide;
  logic [63:0] curPayload;

  egress_ts_poller #(
    .NUM_PORTS(NP), .ADDR_W(AW), .BASE_ADDR(BASE), .ADDR_STRIDE(STRIDE),
    .MAX_READS(MR), .GAP_CYCLES(G)
  ) u0 (
    .clk(clk), .rstN(rstN), .startI(startI), .portI(portI), .wideI(wideI),
    .rdReqO(rdReqO), .rdAddrO(rdAddrO), .rdWideO(rdWideO),
    .rdRspValidI(rdRspValidI), .rdRspErrI(rdRspErrI), .rdRspDataI(rdRspDataI),
    .doneO(doneO), .tsO(tsO), .timeoutO(timeoutO), .errO(errO)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Responder: models the register-read interface
  initial begin
    forever begin
      @(negedge clk);
      if (rdReqO) begin
        readsSeen++;
        // R1
        chk(rdAddrO == AW'(BASE + curPort * STRIDE), "R1", "address",
            64'(rdAddrO), 64'(BASE + curPort * STRIDE));
        chk(rdWideO == curWide, "R1", "layout", 64'(rdWideO), 64'(curWide));
        // R4
        if (readsSeen > 1)
          chk(cyc - lastRspCyc == G + 1, "R4", "retry gap",
              64'(cyc - lastRspCyc), 64'(G + 1));
        repeat (LAT - 1) @(negedge clk);
        rdRspValidI = 1'b1;
        if (readsSeen <= curBusy || curKind == 2) begin
          rdRspErrI  = 1'b0;
          rdRspDataI = 64'hA5A5_5A5A_F0F0_0F0E;
        end else if (curKind == 1) begin
          rdRspErrI  = 1'b1;
          rdRspDataI = 64'hFFFF_FFFF_FFFF_FFFF;
        end else begin
          rdRspErrI  = 1'b0;
          rdRspDataI = curPayload;
        end
        lastRspCyc = cyc;
        @(negedge clk);
        rdRspValidI = 1'b0;
        rdRspErrI   = 1'b0;
        rdRspDataI  = '0;
      end
    end
  end

  // Monitor: pops the scoreboard when the engine reports
  initial begin
    forever begin
      @(negedge clk);
      if (doneO) begin
        exp_t e;
        if (expQ.size() == 0) begin
          chk(1'b0, "R9", "unexpected done", 64'd1, 64'd0);
        end else begin
          e = expQ.pop_front();
          // R2
          chk(cyc == lastRspCyc + 1, "R2", "done latency",
              64'(cyc - lastRspCyc), 64'd1);
          // R3
          chk(readsSeen == e.reads, "R3", "read count", 64'(readsSeen), 64'(e.reads));
          chk(timeoutO == (e.kind == 2), "R3", "timeout flag", 64'(timeoutO), 64'(e.kind == 2));
          // R7
          chk(errO == (e.kind == 1), "R7", "error flag", 64'(errO), 64'(e.kind == 1));
          // R5 R6
          chk(tsO == e.ts, "R5/R6", "timestamp", 64'(tsO), 64'(e.ts));
        end
        opsDone++;
        @(negedge clk);
        // R8
        chk(!doneO && !errO && !timeoutO, "R8", "single-cycle done",
            64'({doneO, errO, timeoutO}), 64'd0);
      end
    end
  end

  task automatic runOp(input int port, input bit wide, input int busy,
                       input int kind, input logic [63:0] payload,
                       input logic [31:0] expTs, input bit poke);
    exp_t e;
    int target;
    target = opsDone + 1;
    curPort = port; curWide = wide; curBusy = busy; curKind = kind;
    curPayload = payload; readsSeen = 0;
    e.kind = kind; e.ts = expTs;
    e.reads = (kind == 2) ? MR : busy + 1;
    expQ.push_back(e);
    @(negedge clk);
    startI = 1'b1; portI = 2'(port); wideI = wide;
    @(negedge clk);
    startI = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      // R9: conflicting start while busy
      startI = 1'b1; portI = 2'(port + 1); wideI = ~wide;
      @(negedge clk);
      startI = 1'b0;
    end
    wait (opsDone == target);
    repeat (G + 2 * LAT + 4) @(negedge clk);
    // R3 R7 R9: nothing further after the end
    chk(readsSeen == e.reads, "R9", "no reads after done", 64'(readsSeen), 64'(e.reads));
    chk(opsDone == target, "R9", "no extra done", 64'(opsDone), 64'(target));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R10
    chk(!rdReqO && !doneO, "R10", "idle after reset", 64'({rdReqO, doneO}), 64'd0);
    runOp(0, 1'b0, 0, 0, 64'h0000_0000_ABCD_EF01, 32'h00AB_CDEF, 1'b0); // R5
    runOp(2, 1'b1, 3, 0, 64'h1234_5678_9ABC_DEF1, 32'h1234_5678, 1'b0); // R6 R4
    runOp(1, 1'b0, MR - 1, 0, 64'hFFFF_FFFF_8000_00FF, 32'h0080_0000, 1'b0); // R5 last read
    runOp(3, 1'b1, 0, 2, 64'h0, 32'h0, 1'b0);                         // R3
    runOp(1, 1'b0, 2, 1, 64'h0, 32'h0, 1'b0);                         // R7
    runOp(0, 1'b1, 2, 0, 64'h0000_00FF_0000_0001, 32'h0000_00FF, 1'b1); // R9 R6
    runOp(3, 1'b0, 0, 0, 64'hDEAD_BEEF_0000_0101, 32'h0000_0001, 1'b0); // R5
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", opsDone, 7);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule